// File: doc/BRIEF.md
# Inter-Core Message Interrupt Hub

The hub lets any of up to four processor cores interrupt any core, itself included, and hand it a 16-bit message. Each core has a byte-addressed window of 8 bytes on a simple 32-bit read/write bus. The window holds two words: a command word the core writes, and a mailbox word that reports what it has been sent. The hub drives one level interrupt line per core. That line stays high until the receiving core clears it with a command of its own.

To send, a core writes its command word with the send bit set, a target core index and a payload. The target's mailbox is then overwritten with a pending flag, the sender's index and the payload, and the target's line rises. To clear, a core writes its command word with the clear bit set. This drops the pending flag in its own mailbox and lowers its own line. A single write may do both. The send is applied first and the clear second.

Read data is combinational from the address. At most one bus access happens per cycle.

Top module: `ipi_hub`

## Requirements
- R1: After reset, every command word and every mailbox word reads as zero, and every `irq_o` bit is low.
- R2: A write to a core's command word (byte address bits [ADDR_W-1:3] = core index, bit 2 = 0) stores all 32 bits. A later read of that word returns the same value, whatever the bits contain.
- R3: A command write with bit 30 (send) set and bits 29:16 naming an existing core replaces that core's mailbox (bit 2 = 1) with {bit31=0, bit30=1, bits29:16=writer index, bits15:0=command bits 15:0}. The target's `irq_o` bit is high from the following cycle on.
- R4: A command write with bit 31 (clear) set clears only bit 30 of the writer's own mailbox and keeps bits 29:0. The writer's `irq_o` bit is low from the following cycle on.
- R5: When one write sets both send and clear and the writer targets itself, the mailbox takes the new sender and payload, and the writer ends up not pending with its line low.
- R6: When one write sets both send and clear and the target is another core, the target becomes pending and the writer's own pending flag is cleared, in the same cycle.
- R7: Writes to a mailbox word change no register and no `irq_o` bit.
- R8: A send naming a target index at or above NUM_CORES changes no mailbox and no line. The command word is still stored.
- R9: An access whose core index is at or above NUM_CORES reads zero and changes nothing.
- R10: Each `irq_o` bit always equals bit 30 of its core's mailbox. It changes only on the clock edge that completes a command write.
- R11: A send to a core that is already pending overwrites its mailbox with the newer sender and payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | NUM_CORES | Level interrupt per core |

## Verification
Two functions can fall in the same cycle: delivering a send to a target and clearing the writer's own pending flag. The bench provokes this with single writes that set both command bits. In one case the writer targets itself while it is already pending. In the other it targets a different core. The bench judges the result against a behavioural model that applies send before clear, and it compares the interrupt vector with that model on every clock.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W  = 32;
  localparam int CORE_FW = 14;
  localparam int MSG_W   = 16;

  typedef struct packed {
    logic               clr;
    logic               snd;
    logic [CORE_FW-1:0] dst;
    logic [MSG_W-1:0]   msg;
  } cmd_word_t;

  typedef struct packed {
    logic               rsvd;
    logic               pend;
    logic [CORE_FW-1:0] src;
    logic [MSG_W-1:0]   msg;
  } mbox_word_t;

  // Mailbox value deposited by a send.
  function automatic mbox_word_t stamp_mbox(input logic [CORE_FW-1:0] src,
                                            input logic [MSG_W-1:0] msg);
    mbox_word_t m;
    m.rsvd = 1'b0;
    m.pend = 1'b1;
    m.src  = src;
    m.msg  = msg;
    return m;
  endfunction

  // Mailbox value after a clear: only the pending flag drops.
  function automatic mbox_word_t drop_pend(input mbox_word_t m);
    mbox_word_t r;
    r      = m;
    r.pend = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec #(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 6,
  localparam int IDX_W    = ADDR_W - 3
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              slot_ok,
  output logic              pick_mbox,
  output logic              cmd_wr,
  output logic              mbox_wr
);
  logic [1:0] unused_lsb;
  assign unused_lsb = bus_addr[1:0];

  assign slot_idx  = bus_addr[ADDR_W-1:3];
  assign pick_mbox = bus_addr[2];
  assign slot_ok   = int'(slot_idx) < NUM_CORES;
  assign cmd_wr    = bus_we && slot_ok && !pick_mbox;
  assign mbox_wr   = bus_we && slot_ok && pick_mbox;
endmodule

// File: rtl/ipi_cmd_gen.sv
module ipi_cmd_gen
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int IDX_W     = 3
) (
  input  logic                 cmd_wr,
  input  logic [IDX_W-1:0]     writer_idx,
  input  logic [WORD_W-1:0]    wdata,
  output logic                 snd_req,
  output logic                 snd_fire,
  output logic [CORE_FW-1:0]   snd_dst,
  output logic                 clr_fire,
  output mbox_word_t           stamp
);
  cmd_word_t cw;
  assign cw       = cmd_word_t'(wdata);
  assign snd_req  = cmd_wr && cw.snd;
  assign snd_dst  = cw.dst;
  assign snd_fire = snd_req && (int'(cw.dst) < NUM_CORES);
  assign clr_fire = cmd_wr && cw.clr;
  assign stamp    = stamp_mbox(CORE_FW'(writer_idx), cw.msg);
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              snd_hit,
  input  mbox_word_t        stamp,
  input  logic              clr_hit,
  output logic [WORD_W-1:0] cmd_q,
  output mbox_word_t        mbox_q,
  output logic              irq_q
);
  mbox_word_t mbox_d;

  // Send lands first, clear is applied on top of it.
  always_comb begin
    mbox_d = mbox_q;
    if (snd_hit) mbox_d = stamp;
    if (clr_hit) mbox_d = drop_pend(mbox_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mbox_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cmd_load) cmd_q <= cmd_wdata;
      mbox_q <= mbox_d;
      irq_q  <= mbox_d.pend;
    end
  end
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]   slot_idx;
  logic               slot_ok;
  logic               pick_mbox;
  logic               cmd_wr;
  logic               mbox_wr;
  logic               snd_req;
  logic               snd_fire;
  logic [CORE_FW-1:0] snd_dst;
  logic               clr_fire;
  mbox_word_t         stamp;

  logic [WORD_W-1:0]  cmd_arr  [NUM_CORES];
  mbox_word_t         mbox_arr [NUM_CORES];

  ipi_addr_dec #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .slot_idx  (slot_idx),
    .slot_ok   (slot_ok),
    .pick_mbox (pick_mbox),
    .cmd_wr    (cmd_wr),
    .mbox_wr   (mbox_wr)
  );

  ipi_cmd_gen #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_cmd (
    .cmd_wr     (cmd_wr),
    .writer_idx (slot_idx),
    .wdata      (bus_wdata),
    .snd_req    (snd_req),
    .snd_fire   (snd_fire),
    .snd_dst    (snd_dst),
    .clr_fire   (clr_fire),
    .stamp      (stamp)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
    logic is_writer;
    logic snd_hit;
    assign is_writer = int'(slot_idx) == k;
    assign snd_hit   = snd_fire && (int'(snd_dst) == k);

    ipi_core_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_load  (cmd_wr && is_writer),
      .cmd_wdata (bus_wdata),
      .snd_hit   (snd_hit),
      .stamp     (stamp),
      .clr_hit   (clr_fire && is_writer),
      .cmd_q     (cmd_arr[k]),
      .mbox_q    (mbox_arr[k]),
      .irq_q     (irq_o[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (slot_ok && int'(slot_idx) == k)
        bus_rdata = pick_mbox ? WORD_W'(mbox_arr[k]) : cmd_arr[k];
    end
  end
endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk #(
  parameter int NUM_CORES = 1,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] irq_o,
  input logic                 cmd_wr,
  input logic                 mbox_poke,
  input logic                 stray_wr,
  input logic                 snd_req,
  input logic                 snd_fire,
  input logic [13:0]          snd_dst,
  input logic                 clr_fire,
  input logic [IDX_W-1:0]     slot_idx
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> irq_o == '0);

  assert_mbox_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_poke |=> $stable(irq_o));

  assert_far_target_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snd_req && !snd_fire && !clr_fire |=> $stable(irq_o));

  assert_stray_slot_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> $stable(irq_o));

  assert_quiet_without_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(irq_o));

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    assert_send_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snd_fire && int'(snd_dst) == k && !(clr_fire && int'(slot_idx) == k)
      |=> irq_o[k]);

    assert_clear_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fire && int'(slot_idx) == k |=> !irq_o[k]);
  end
endmodule

bind ipi_hub ipi_hub_chk #(.NUM_CORES(NUM_CORES), .IDX_W(ADDR_W - 3)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .cmd_wr    (cmd_wr),
  .mbox_poke (bus_we && bus_addr[2]),
  .stray_wr  (bus_we && !slot_ok),
  .snd_req   (snd_req),
  .snd_fire  (snd_fire),
  .snd_dst   (snd_dst),
  .clr_fire  (clr_fire),
  .slot_idx  (slot_idx)
);

// File: tb/test_ipi_hub.sv
module test_ipi_hub;
  localparam int NC = 4;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_o;

  int checks = 0;
  int bad = 0;
  bit cmp_on = 0;
  bit done = 0;

  logic [31:0] m_cmd [8];
  logic [31:0] m_box [8];

  always #4 clk = ~clk;

  ipi_hub #(.NUM_CORES(NC), .ADDR_W(AW)) i_ipi_hub (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] adr(input int core, input bit box);
    return AW'(core * 8 + (box ? 4 : 0));
  endfunction

  function automatic logic [NC-1:0] model_irq();
    logic [NC-1:0] v;
    for (int i = 0; i < NC; i++) v[i] = m_box[i][30];
    return v;
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    int core = int'(a) / 8;
    if (core >= NC) return 32'h0;
    return a[2] ? m_box[core] : m_cmd[core];
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d);
    int core = int'(a) / 8;
    int dst  = int'(d[29:16]);
    if (core >= NC || a[2]) return;
    m_cmd[core] = d;
    if (d[30] && dst < NC) m_box[dst] = {2'b01, 14'(core), d[15:0]};
    if (d[31]) m_box[core][30] = 1'b0;
  endfunction

  task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_write(a, d);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 check32(tag, bus_rdata, model_read(a));
  endtask

  task automatic rd_lit(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 check32(tag, bus_rdata, exp);
  endtask

  // R10: the interrupt vector tracks the modelled pending flags every clock.
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (irq_o !== model_irq()) begin
        bad++;
        $display("FAIL R10: irq got %b expected %b", irq_o, model_irq());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_cmd[i] = '0; m_box[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cmp_on = 1;
    // R1: everything clear after reset
    for (int c = 0; c < NC; c++) begin
      rd_lit("R1", adr(c, 0), 32'h0);
      rd_lit("R1", adr(c, 1), 32'h0);
    end
    check32("R1", 32'(irq_o), 32'h0);
    // R2: command word stored verbatim
    wr(adr(1, 0), 32'h0000_ABCD);
    rd_lit("R2", adr(1, 0), 32'h0000_ABCD);
    wr(adr(1, 0), 32'h3FFF_1234);
    rd_lit("R2", adr(1, 0), 32'h3FFF_1234);
    // R3: core 0 sends to core 2
    wr(adr(0, 0), 32'h4002_5A5A);
    rd_lit("R3", adr(2, 1), 32'h4000_5A5A);
    check32("R3", 32'(irq_o[2]), 32'h1);
    // R11: core 3 overwrites pending core 2
    wr(adr(3, 0), 32'h4002_1111);
    rd_lit("R11", adr(2, 1), 32'h4003_1111);
    // R4: core 2 clears
    wr(adr(2, 0), 32'h8000_0000);
    rd_lit("R4", adr(2, 1), 32'h0003_1111);
    check32("R4", 32'(irq_o[2]), 32'h0);
    rd_lit("R2", adr(2, 0), 32'h8000_0000);
    // R5: core 1 pending, then sends to itself with clear
    wr(adr(0, 0), 32'h4001_0BAD);
    check32("R5", 32'(irq_o[1]), 32'h1);
    wr(adr(1, 0), 32'hC001_7777);
    rd_lit("R5", adr(1, 1), 32'h0001_7777);
    check32("R5", 32'(irq_o[1]), 32'h0);
    // R6: core 1 pending, sends to core 3 and clears itself
    wr(adr(0, 0), 32'h4001_2222);
    wr(adr(1, 0), 32'hC003_0042);
    rd_lit("R6", adr(3, 1), 32'h4001_0042);
    rd_lit("R6", adr(1, 1), 32'h0000_2222);
    check32("R6", 32'(irq_o), 32'b1000);
    // R7: mailbox writes are inert
    wr(adr(3, 1), 32'h0000_0000);
    wr(adr(0, 1), 32'hFFFF_FFFF);
    rd_lit("R7", adr(3, 1), 32'h4001_0042);
    rd_lit("R7", adr(0, 1), 32'h0000_0000);
    check32("R7", 32'(irq_o), 32'b1000);
    // R8: send to a missing core
    wr(adr(0, 0), 32'h4004_9999);
    rd_lit("R8", adr(0, 0), 32'h4004_9999);
    wr(adr(2, 0), 32'h7FFF_1234);
    for (int c = 0; c < NC; c++) rd("R8", adr(c, 1));
    check32("R8", 32'(irq_o), 32'b1000);
    // R9: slots beyond the core count
    wr(adr(5, 0), 32'h4000_5555);
    wr(adr(7, 0), 32'h8000_0000);
    rd_lit("R9", adr(5, 0), 32'h0);
    rd_lit("R9", adr(6, 1), 32'h0);
    rd_lit("R9", adr(0, 1), 32'h0000_0000);
    check32("R9", 32'(irq_o), 32'b1000);
    // R4: clear with nothing pending changes nothing else
    wr(adr(0, 0), 32'h8000_0000);
    rd("R4", adr(0, 1));
    // R3/R10: back-to-back sends to every core, then clears
    for (int c = 0; c < NC; c++) wr(adr(c, 0), {2'b01, 14'((c + 1) % NC), 16'(c * 16'h0101)});
    for (int c = 0; c < NC; c++) rd("R3", adr(c, 1));
    for (int c = 0; c < NC; c++) wr(adr(c, 0), 32'h8000_0000);
    for (int c = 0; c < NC; c++) rd("R4", adr(c, 1));
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule